// File: doc/BRIEF.md
# Programmable Status LED Driver

This block drives a bank of active-low status LED outputs, one per port channel, with the LEDs wired to the supply. Each output works in one of five modes. It can follow the channel's live link status, follow its full-duplex status, be held lit, be held dark, or blink on its own at a fixed rate. A single blink divider, clocked from the 10 MHz reference, times the blink, so no external timer is needed.

Software sets the modes through a simple write port. Address 0 holds a global word. Addresses 1 to NCH hold one mode word per channel. The global word can override every channel with a single shared mode. The output is a pure function of the stored configuration, the status inputs and the blink phase. A configuration write therefore shows on the pins one clock edge later.

Top module: `led_mode_drv`

## Requirements
- R1: After reset, every channel is in link mode and the global override is off. The blink counter is cleared, and the blink phase starts in the lit half.
- R2: Mode code 3'b000 (link) drives `led_n[i]` to the inverse of `link_up[i]`, so the LED is lit (low) while the link is up.
- R3: Mode code 3'b001 (duplex) drives `led_n[i]` to the inverse of `full_dplx[i]`.
- R4: Mode code 3'b010 (on) drives `led_n[i]` low whatever the status inputs are.
- R5: Mode code 3'b011 (off) and the unused codes 3'b101, 3'b110 and 3'b111 drive `led_n[i]` high.
- R6: Mode code 3'b100 (blink) gives HALF_CYCLES clocks lit, then HALF_CYCLES clocks dark, repeating. The phase counts from reset release, and all blinking channels share one phase.
- R7: A write to address 0 stores `wr_data[3]` as the global enable and `wr_data[2:0]` as the global mode. While the global enable is 1, every channel uses the global mode. While it is 0, channel i uses its own word.
- R8: A write to address i+1 stores `wr_data[2:0]` as the mode of channel i. The stored per-channel mode survives while the global override is active.
- R9: A write to an address above NCH has no effect on any stored mode or on the outputs.
- R10: The channels are independent. Each can hold a different mode at the same time, and a write to one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | $clog2(NCH+1) | 0 = global word, i+1 = channel i word |
| wr_data | input | 8 | Write data (global: bit 3 enable, bits 2:0 mode; channel: bits 2:0 mode) |
| link_up | input | NCH | Per-channel link status |
| full_dplx | input | NCH | Per-channel full-duplex status |
| led_n | output | NCH | Active-low LED outputs |

## Verification
On every cycle, the assertions check the blink divider's hold and toggle behaviour and its reset value. They also check that the global override steers each channel's effective mode, that out-of-range writes leave the stored modes unchanged, and that each effective mode gives its required pin level. The placement of the lit and dark windows in absolute time since reset shows only in the bench, which counts edges against its own model. So does the survival of per-channel modes across an override and back, and the mapping from a write to the one channel it targets. Random writes mixed with random status patterns cover the interaction of all five modes across the channels.

// File: rtl/led_mode_drv.sv
module led_mode_drv #(
  parameter int NCH         = 4,
  parameter int HALF_CYCLES = 1_000_000,
  localparam int AW = $clog2(NCH + 1),
  localparam int CW = $clog2(HALF_CYCLES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [NCH-1:0] link_up,
  input  logic [NCH-1:0] full_dplx,
  output logic [NCH-1:0] led_n
);

  localparam logic [2:0] M_LINK  = 3'd0;
  localparam logic [2:0] M_DPLX  = 3'd1;
  localparam logic [2:0] M_ON    = 3'd2;
  localparam logic [2:0] M_BLINK = 3'd4;

  logic [NCH-1:0][2:0] ch_mode;
  logic [NCH-1:0][2:0] eff_mode;
  logic [2:0]          g_mode;
  logic                g_en;
  logic [CW-1:0]       cnt;
  logic                lit_phase;
  logic                wrap;
  logic [NCH-1:0]      lit;

  assign wrap = (cnt == CW'(HALF_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      g_en   <= 1'b0;
      g_mode <= M_LINK;
    end else if (wr_en && wr_addr == '0) begin
      g_en   <= wr_data[3];
      g_mode <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      lit_phase <= 1'b1;
    end else if (wrap) begin
      cnt       <= '0;
      lit_phase <= ~lit_phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        ch_mode[g] <= M_LINK;
      else if (wr_en && wr_addr == AW'(g + 1))
        ch_mode[g] <= wr_data[2:0];
    end

    assign eff_mode[g] = g_en ? g_mode : ch_mode[g];

    always_comb begin
      case (eff_mode[g])
        M_LINK:  lit[g] = link_up[g];
        M_DPLX:  lit[g] = full_dplx[g];
        M_ON:    lit[g] = 1'b1;
        M_BLINK: lit[g] = lit_phase;
        default: lit[g] = 1'b0;
      endcase
    end

    assign led_n[g] = ~lit[g];
  end

endmodule

// File: rtl/led_mode_drv_chk.sv
module led_mode_drv_chk #(
  parameter int NCH  = 4,
  parameter int HALF = 8,
  parameter int AW   = 3,
  parameter int CW   = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic [NCH-1:0]      led_n,
  input logic [NCH-1:0]      link_up,
  input logic [NCH-1:0]      full_dplx,
  input logic [NCH-1:0][2:0] ch_mode,
  input logic [NCH-1:0][2:0] eff_mode,
  input logic [2:0]          g_mode,
  input logic                g_en,
  input logic [CW-1:0]       cnt,
  input logic                lit_phase
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cnt == '0 && lit_phase && !g_en && ch_mode == '0));

  a_r6_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt != CW'(HALF - 1)) |=> $stable(lit_phase));

  a_r6_phase_flip: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(HALF - 1)) |=> (lit_phase != $past(lit_phase) && cnt == '0));

  a_r9_range_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > AW'(NCH)) |=> ($stable(ch_mode) && $stable(g_mode) && $stable(g_en)));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r7_override: assert property (@(posedge clk) disable iff (rst)
      g_en |-> (eff_mode[i] == g_mode));
    a_r2_link: assert property (@(posedge clk) disable iff (rst)
      (eff_mode[i] == 3'd0) |-> (led_n[i] == !link_up[i]));
    a_r3_duplex: assert property (@(posedge clk) disable iff (rst)
      (eff_mode[i] == 3'd1) |-> (led_n[i] == !full_dplx[i]));
    a_r4_forced_on: assert property (@(posedge clk) disable iff (rst)
      (eff_mode[i] == 3'd2) |-> !led_n[i]);
    a_r5_forced_off: assert property (@(posedge clk) disable iff (rst)
      (eff_mode[i] == 3'd3 || eff_mode[i] > 3'd4) |-> led_n[i]);
    a_r6_blink_out: assert property (@(posedge clk) disable iff (rst)
      (eff_mode[i] == 3'd4) |-> (led_n[i] == !lit_phase));
  end

endmodule

bind led_mode_drv led_mode_drv_chk #(
  .NCH(NCH), .HALF(HALF_CYCLES), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .led_n(led_n),
  .link_up(link_up), .full_dplx(full_dplx), .ch_mode(ch_mode),
  .eff_mode(eff_mode), .g_mode(g_mode), .g_en(g_en), .cnt(cnt),
  .lit_phase(lit_phase)
);

// File: tb/led_mode_drv_bench.sv
module led_mode_drv_bench;
  localparam int NCH  = 4;
  localparam int HALF = 6;
  localparam int AW   = $clog2(NCH + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] link_up = '0;
  logic [NCH-1:0] full_dplx = '0;
  logic [NCH-1:0] led_n;

  int checks = 0;
  int fails  = 0;
  int ticks  = 0;
  bit done   = 0;

  logic [2:0] m_ch [NCH];
  logic [2:0] m_gmode = 3'd0;
  logic       m_gen   = 1'b0;

  led_mode_drv #(.NCH(NCH), .HALF_CYCLES(HALF)) u_led_mode_drv (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .link_up(link_up), .full_dplx(full_dplx), .led_n(led_n)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ticks <= 0;
    else     ticks <= ticks + 1;
  end

  function automatic logic exp_led(logic [2:0] m, logic lk, logic dp, logic ph);
    case (m)
      3'd0:    return ~lk;
      3'd1:    return ~dp;
      3'd2:    return 1'b0;
      3'd4:    return ~ph;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string mode_tag(logic [2:0] m, logic ovr);
    if (ovr) return "R7";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check_all(string tag);
    logic ph;
    ph = ((ticks / HALF) % 2) == 0;
    for (int c = 0; c < NCH; c++) begin
      logic [2:0] em;
      logic e;
      string t;
      em = m_gen ? m_gmode : m_ch[c];
      e  = exp_led(em, link_up[c], full_dplx[c], ph);
      t  = (tag != "") ? tag : mode_tag(em, m_gen);
      checks++;
      if (led_n[c] !== e) begin
        fails++;
        $display("FAIL %s ch%0d led_n=%b expected %b (mode %0d)", t, c, led_n[c], e, em);
      end
    end
  endtask

  task automatic mirror_write(logic [AW-1:0] a, logic [7:0] d);
    if (a == 0) begin
      m_gen = d[3];
      m_gmode = d[2:0];
    end else if (a <= NCH) begin
      m_ch[a-1] = d[2:0];
    end
  endtask

  task automatic write_reg(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    mirror_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd2024);
    for (int c = 0; c < NCH; c++) m_ch[c] = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, link mode, phase lit
    link_up = 4'b1111;
    @(negedge clk); check_all("R1");
    link_up = 4'b0101;
    @(negedge clk); check_all("R1");

    // R3, R4, R5, R10: mixed channel modes
    write_reg(1, 8'h01);
    write_reg(2, 8'h02);
    write_reg(3, 8'h03);
    write_reg(4, 8'h00);
    full_dplx = 4'b0001; link_up = 4'b1000;
    @(negedge clk); check_all("R10");
    full_dplx = 4'b1110; link_up = 4'b0111;
    @(negedge clk); check_all("R10");

    // R5: unused codes are dark
    write_reg(1, 8'h05); write_reg(2, 8'h06); write_reg(3, 8'h07);
    @(negedge clk); check_all("R5");

    // R9: out-of-range writes have no effect
    write_reg(5, 8'h02); write_reg(6, 8'h02); write_reg(7, 8'h0A);
    @(negedge clk); check_all("R9");

    // R6: blink on all channels, watch two full periods
    for (int c = 1; c <= NCH; c++) write_reg(AW'(c), 8'h04);
    for (int k = 0; k < 4 * HALF; k++) begin
      @(negedge clk); check_all("R6");
    end

    // R7, R8: global override then back to per-channel modes
    write_reg(1, 8'h02);
    write_reg(0, 8'h0B);
    @(negedge clk); check_all("R7");
    write_reg(0, 8'h02);
    @(negedge clk); check_all("R8");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      check_all("");
      link_up   = NCH'($urandom);
      full_dplx = NCH'($urandom);
      wr_en     = ($urandom % 4) == 0;
      wr_addr   = AW'($urandom);
      wr_data   = 8'($urandom);
      if (wr_en) mirror_write(wr_addr, wr_data);
    end
    @(negedge clk);
    check_all("");
    wr_en = 1'b0;
    finish_run();
  end
endmodule